// File: doc/BRIEF.md
# Bit-serial distributed-arithmetic 8-point DCT engine

The block computes the eight coefficients of a one-dimensional, eight-point discrete cosine transform of eight signed 12-bit samples, and it uses no multiplier. A start strobe captures the eight samples into a bank of rotating shift registers. Each clock cycle the bank presents one bit from every sample, least significant bit first, as an 8-bit table address. A single accumulator adds the selected table entry with a right shift. The bank rotates back to its loaded contents after twelve cycles. This lets the same vector be replayed once per output index, and each replay reads a different table.

One pass therefore takes one 12-cycle word and yields one coefficient, so a full block takes 96 cycles. A caller that wants fewer coefficients can limit the block to its first K passes. An enable input, sampled at the start of each pass, lets power control logic leave a pass idle. In that case the shift bank keeps its rhythm and that coefficient is simply not produced.

Top module: `da_dct8`

## Requirements
- R1: After reset, busy, coef_valid, coef_idx and coef_out are all zero.
- R2: A start pulse while idle captures sample_in and raises busy from the next cycle. Sample n occupies bits [12n+11:12n] in two's complement.
- R3: Coefficient k equals (S + 512) >> 10 with an arithmetic shift, where S = sum over n of x[n]·C[k][n]. C[k][n] is the integer nearest to 1024·a·cos((2n+1)kπ/16), rounded half away from zero, with a = sqrt(1/8) for k = 0 and a = 1/2 otherwise. The result is 15-bit two's complement.
- R4: Coefficients leave in ascending index order. Coefficient p shows up with a one-cycle coef_valid pulse and coef_idx = p exactly 12·(p+1) cycles after the edge that accepted start.
- R5: The most significant bit of each sample carries negative weight, so extreme inputs such as -2048 and 2047 give the R3 value.
- R6: The value of en in the first cycle of pass p decides that pass. If en is low there, no coefficient p is produced. The value of en in the other cycles of the pass has no effect, and later passes still keep their R4 timing and R3 values.
- R7: npass values 1 to 7 limit the block to that many passes, and 0 or any value above 8 runs all 8. busy stays high for exactly 12 times the number of passes.
- R8: A start pulse while busy is ignored: the running block's coefficients, timing and busy length are unchanged.
- R9: While coef_valid is low, coef_out and coef_idx hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block with the presented samples when idle |
| sample_in | input | 96 | Eight packed signed 12-bit samples, sample n at bits [12n+11:12n] |
| npass | input | 4 | Number of passes to run (0 or above 8 means 8) |
| en | input | 1 | Pass enable, sampled in each pass's first cycle |
| busy | output | 1 | A block is in progress |
| coef_valid | output | 1 | One-cycle strobe for a new coefficient |
| coef_idx | output | 3 | Index of the presented coefficient |
| coef_out | output | 15 | Signed coefficient value |

## Verification
busy is due on the cycle after the accepting edge. Coefficient p is due exactly 12·(p+1) edges after that edge, and busy falls on the same edge that delivers the last pass. The bench counts falling edges from the accepting edge and compares the outputs on each one against a schedule it builds from npass and the per-pass enable mask. The schedule covers coef_valid on every cycle, the index and value only on the due cycles, and busy up to one cycle past its end. This covers skipped passes and a start pulse that arrives while busy. en is randomised outside the first cycle of each pass so that only the sampled value can matter.

// File: rtl/dct_da_pkg.sv
package dct_da_pkg;

  // Scaled cosine constant for output k, input n, rounded half away from zero.
  function automatic int dct_const(int k, int n, int npt, int frac);
    real ang;
    real amp;
    real v;
    ang = 3.14159265358979 * real'((2 * n + 1) * k) / real'(2 * npt);
    amp = (k == 0) ? $sqrt(1.0 / real'(npt)) : $sqrt(2.0 / real'(npt));
    v   = amp * $cos(ang) * real'(1 << frac);
    if (v >= 0.0) return int'($floor(v + 0.5));
    return -int'($floor(-v + 0.5));
  endfunction

  // Table entry: sum of the constants of every input whose address bit is set.
  function automatic int lut_sum(int k, int addr, int npt, int frac);
    int s;
    s = 0;
    for (int n = 0; n < npt; n++)
      if (addr[n]) s += dct_const(k, n, npt, frac);
    return s;
  endfunction

  // Clamp a requested pass count: 0 or over the maximum means all passes.
  function automatic int pass_limit(int req, int npt);
    if (req == 0 || req > npt) return npt;
    return req;
  endfunction

endpackage

// File: rtl/dct_srb.sv
module dct_srb #(
  parameter int N_PT = 8,
  parameter int WORD = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   rotate,
  input  logic [N_PT*WORD-1:0]   din,
  output logic [N_PT-1:0]        slice
);
  logic [WORD-1:0] regs [N_PT];

  for (genvar n = 0; n < N_PT; n++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)         regs[n] <= '0;
      else if (load)   regs[n] <= din[n*WORD +: WORD];
      else if (rotate) regs[n] <= {regs[n][0], regs[n][WORD-1:1]};
    end
    assign slice[n] = regs[n][0];
  end
endmodule

// File: rtl/dct_lut.sv
module dct_lut #(
  parameter  int N_PT = 8,
  parameter  int FRAC = 10,
  parameter  int LW   = 14,
  localparam int PW   = $clog2(N_PT)
) (
  input  logic [PW-1:0]          sel,
  input  logic [N_PT-1:0]        addr,
  output logic signed [LW-1:0]   val
);
  localparam int DEPTH = 2 ** N_PT;

  logic signed [LW-1:0] tbl [N_PT][DEPTH];

  for (genvar k = 0; k < N_PT; k++) begin : g_set
    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
      localparam int V = dct_da_pkg::lut_sum(k, a, N_PT, FRAC);
      assign tbl[k][a] = LW'(V);
    end
  end

  assign val = tbl[sel][addr];
endmodule

// File: rtl/dct_da_acc.sv
module dct_da_acc #(
  parameter  int LW    = 14,
  parameter  int WORD  = 12,
  parameter  int FRAC  = 10,
  parameter  int OUT_W = 15,
  parameter  int PW    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    gate,
  input  logic                    first,
  input  logic                    last,
  input  logic [PW-1:0]           pass,
  input  logic signed [LW-1:0]    lut_in,
  output logic signed [OUT_W-1:0] coef_out,
  output logic [PW-1:0]           coef_idx,
  output logic                    coef_valid
);
  // Room for the widest partial sum plus WORD guard bits below, so no bit is shifted out.
  localparam int AW = LW + WORD + 2;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] term;
  logic signed [AW-1:0] sum_w;
  logic signed [AW-1:0] nxt;

  // Sign slice carries negative weight.
  function automatic logic signed [AW-1:0] slice_term(logic signed [LW-1:0] v, logic neg);
    logic signed [AW-1:0] e;
    e = AW'(v);
    return neg ? -e : e;
  endfunction

  always_comb begin
    term  = slice_term(lut_in, last);
    sum_w = (first ? '0 : acc) + (term <<< WORD);
    nxt   = sum_w >>> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      coef_out   <= '0;
      coef_idx   <= '0;
      coef_valid <= 1'b0;
    end else begin
      coef_valid <= 1'b0;
      if (gate) begin
        acc <= nxt;
        if (last) begin
          coef_valid <= 1'b1;
          coef_idx   <= pass;
          coef_out   <= OUT_W'((nxt + HALF) >>> FRAC);
        end
      end
    end
  end
endmodule

// File: rtl/da_dct8.sv
module da_dct8 #(
  parameter int N_PT  = 8,
  parameter int WORD  = 12,
  parameter int FRAC  = 10,
  parameter int OUT_W = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [N_PT*WORD-1:0]        sample_in,
  input  logic [$clog2(N_PT):0]       npass,
  input  logic                        en,
  output logic                        busy,
  output logic                        coef_valid,
  output logic [$clog2(N_PT)-1:0]     coef_idx,
  output logic signed [OUT_W-1:0]     coef_out
);
  localparam int PW = $clog2(N_PT);
  localparam int LM = PW + 1;
  localparam int BW = $clog2(WORD);
  localparam int LW = FRAC + 4;

  logic          busy_q;
  logic [BW-1:0] bit_q;
  logic [PW-1:0] pass_q;
  logic [LM-1:0] lim_q;
  logic          gate_q;

  // Named events for the checker.
  logic accept;
  logic first_bit;
  logic last_bit;
  logic last_pass;
  logic pass_end;
  logic acc_gate;

  logic [N_PT-1:0]       slice;
  logic signed [LW-1:0]  lut_val;

  assign accept    = start && !busy_q;
  assign first_bit = (bit_q == '0);
  assign last_bit  = (bit_q == BW'(WORD - 1));
  assign last_pass = ({1'b0, pass_q} == lim_q - LM'(1));
  assign pass_end  = busy_q && last_bit;
  assign acc_gate  = busy_q && (first_bit ? en : gate_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      pass_q <= '0;
      lim_q  <= '0;
      gate_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      bit_q  <= '0;
      pass_q <= '0;
      lim_q  <= LM'(dct_da_pkg::pass_limit(int'(npass), N_PT));
    end else if (busy_q) begin
      if (first_bit) gate_q <= en;
      if (last_bit) begin
        bit_q  <= '0;
        pass_q <= pass_q + PW'(1);
        if (last_pass) busy_q <= 1'b0;
      end else begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

  dct_srb #(.N_PT(N_PT), .WORD(WORD)) u_srb (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .rotate (busy_q),
    .din    (sample_in),
    .slice  (slice)
  );

  dct_lut #(.N_PT(N_PT), .FRAC(FRAC), .LW(LW)) u_lut (
    .sel  (pass_q),
    .addr (slice),
    .val  (lut_val)
  );

  dct_da_acc #(.LW(LW), .WORD(WORD), .FRAC(FRAC), .OUT_W(OUT_W), .PW(PW)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .gate       (acc_gate),
    .first      (first_bit),
    .last       (last_bit),
    .pass       (pass_q),
    .lut_in     (lut_val),
    .coef_out   (coef_out),
    .coef_idx   (coef_idx),
    .coef_valid (coef_valid)
  );

  assign busy = busy_q;
endmodule

// File: rtl/da_dct8_chk.sv
module da_dct8_chk #(
  parameter int PW    = 3,
  parameter int OUT_W = 15
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    busy,
  input logic                    pass_end,
  input logic                    coef_valid,
  input logic [PW-1:0]           coef_idx,
  input logic signed [OUT_W-1:0] coef_out
);
  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    coef_valid |=> !coef_valid);

  // R4
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    coef_valid |-> $past(pass_end));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R9
  hold_coef_chk: assert property (@(posedge clk) disable iff (rst)
    !coef_valid |-> ($stable(coef_out) && $stable(coef_idx)));

  // R7
  valid_in_block_chk: assert property (@(posedge clk) disable iff (rst)
    coef_valid |-> $past(busy));
endmodule

bind da_dct8 da_dct8_chk #(.PW($clog2(N_PT)), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .pass_end   (pass_end),
  .coef_valid (coef_valid),
  .coef_idx   (coef_idx),
  .coef_out   (coef_out)
);

// File: tb/tb_da_dct8.sv
module tb_da_dct8;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [95:0] sample_in = '0;
  logic [3:0]  npass = '0;
  logic        en = 1'b1;
  logic        busy;
  logic        coef_valid;
  logic [2:0]  coef_idx;
  logic signed [14:0] coef_out;

  int checks = 0;
  int errors = 0;
  logic signed [14:0] last_coef = '0;
  logic [2:0]         last_idx = '0;

  always #4 clk = ~clk;

  da_dct8 dut (
    .clk(clk), .rst(rst), .start(start), .sample_in(sample_in), .npass(npass),
    .en(en), .busy(busy), .coef_valid(coef_valid), .coef_idx(coef_idx), .coef_out(coef_out)
  );

  function automatic int cst(int k, int n);
    real r;
    r = 1024.0 * ((k == 0) ? 0.35355339059327 : 0.5) * $cos(3.14159265358979 * (2 * n + 1) * k / 16.0);
    return (r >= 0.0) ? int'($floor(r + 0.5)) : -int'($floor(-r + 0.5));
  endfunction

  // R3: rounded dot product
  function automatic int want_coef(int x[8], int k);
    int s;
    s = 0;
    for (int n = 0; n < 8; n++) s += x[n] * cst(k, n);
    return (s + 512) >>> 10;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_block(input int x[8], input int k_in, input bit [7:0] mask,
                           input int dup_at, input string tag);
    int kk;
    logic [95:0] pk;
    kk = (k_in == 0 || k_in > 8) ? 8 : k_in;
    for (int n = 0; n < 8; n++) pk[n*12 +: 12] = x[n][11:0];
    @(negedge clk);
    sample_in = pk;
    npass = 4'(k_in);
    start = 1'b1;
    for (int c = 0; c <= 12 * kk + 2; c++) begin
      bit ev;
      int p;
      @(negedge clk);
      // drive for the next edge
      if (c == dup_at) begin
        start = 1'b1;
        sample_in = ~pk;
        npass = 4'(k_in + 1);
      end else begin
        start = 1'b0;
      end
      if (c % 12 == 0 && c / 12 < 8) en = mask[c / 12];
      else en = 1'($urandom_range(0, 1));
      // R2 / R7: busy length
      check(busy == (c < 12 * kk), (tag == "") ? "R7" : tag, "busy", int'(busy), int'(c < 12 * kk));
      p = c / 12 - 1;
      ev = (c > 0) && (c % 12 == 0) && (p < kk) && mask[p];
      // R4 / R6: valid schedule
      check(coef_valid == ev, (tag == "") ? "R4" : tag, "coef_valid", int'(coef_valid), int'(ev));
      if (ev && coef_valid) begin
        check(coef_idx == 3'(p), "R4", "coef_idx", int'(coef_idx), p);
        check(int'(coef_out) == want_coef(x, p), (tag == "") ? "R3" : tag, "coef_out",
              int'(coef_out), want_coef(x, p));
      end
      if (!coef_valid) begin
        // R9: hold while not valid
        check(coef_out == last_coef && coef_idx == last_idx, "R9", "hold", int'(coef_out), int'(last_coef));
      end
      last_coef = coef_out;
      last_idx  = coef_idx;
    end
    start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int x[8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!busy && !coef_valid && coef_out == '0 && coef_idx == '0, "R1", "reset state",
          int'({busy, coef_valid, coef_idx, coef_out}), 0);
    void'($urandom(32'h5eed_1234));

    // R3: impulse and flat inputs
    x = '{100, 0, 0, 0, 0, 0, 0, 0};
    run_block(x, 8, 8'hFF, -1, "R3");
    x = '{500, 500, 500, 500, 500, 500, 500, 500};
    run_block(x, 8, 8'hFF, -1, "R3");
    // R5: extremes
    x = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048};
    run_block(x, 8, 8'hFF, -1, "R5");
    x = '{2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048};
    run_block(x, 8, 8'hFF, -1, "R5");
    x = '{-1, -2048, 2047, 0, 1, -1, 2047, -2047};
    run_block(x, 8, 8'hFF, -1, "R5");
    // R7: pass limits
    x = '{10, 200, -300, 400, -50, 60, 700, -800};
    run_block(x, 1, 8'hFF, -1, "R7");
    run_block(x, 3, 8'hFF, -1, "R7");
    run_block(x, 0, 8'hFF, -1, "R7");
    run_block(x, 13, 8'hFF, -1, "R7");
    // R6: skipped passes
    run_block(x, 8, 8'b1010_0110, -1, "R6");
    run_block(x, 8, 8'h00, -1, "R6");
    // R8: start during a block
    run_block(x, 8, 8'hFF, 30, "R8");
    run_block(x, 2, 8'hFF, 5, "R8");

    for (int b = 0; b < 60; b++) begin
      int k_in;
      bit [7:0] m;
      int dup;
      int kk;
      for (int n = 0; n < 8; n++) x[n] = int'($urandom_range(0, 4095)) - 2048;
      k_in = int'($urandom_range(0, 15));
      kk = (k_in == 0 || k_in > 8) ? 8 : k_in;
      m = 8'($urandom) | 8'($urandom) | 8'($urandom);
      dup = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 12 * kk - 2)) : -1;
      run_block(x, k_in, m, dup, "");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule